// File: doc/BRIEF.md
# Integer ALU with Condition Codes, Y Register and Multiply Step

This block is the integer execution unit of a 32-bit core. It computes one result per cycle from two operands and a 4-bit opcode. The result path is purely combinational. The unit also owns two pieces of architectural state: a 4-bit condition-code register (negative, zero, overflow, carry) and a 32-bit Y register. The next values of both are presented combinationally, and both are registered on the rising clock edge.

A set-cc strobe lets any operation also load the condition codes. The multiply-step operation always updates them. Multiply step is the building block of software multiplication. It shifts the partial product right and brings in the sign of the previous step, given by N xor V. It adds the multiplicand only when the low bit of Y is set, and it shifts the saved low bit of the partial product into the top of Y. The write-Y and read-Y operations move Y to and from the datapath, so that a full product can be assembled by a sequence of steps.

Top module: `cc_alu`

## Requirements
- R1: Opcode 0 (add) gives res_o = a + b. With set-cc, the flags are: Z when the result is zero, N from result bit 31, C when the unsigned result is below a, and V when bit 31 of ~(a^b) & (a^res) is one. Flag bits in flags_nxt_o and flags_o are [3]=N, [2]=Z, [1]=V, [0]=C.
- R2: Opcode 1 (sub) gives res_o = a - b. With set-cc, C is set when a < b unsigned, V is bit 31 of (a^b) & (a^res), and Z and N follow the result.
- R3: Opcode 2 (add with carry) gives a + b + C, and opcode 3 (sub with carry) gives a - b - C, where C is the stored carry flag. With set-cc, C is the true carry out or borrow, and V uses the add rule or the sub rule respectively.
- R4: Opcodes 4 to 9 give a&b, a|b, a^b, a&~b, a|~b and a^~b. With set-cc, Z and N follow the result and V and C are cleared.
- R5: Opcode 10 shifts a left, opcode 11 shifts it right logically and opcode 12 shifts it right arithmetically, copying bit 31 in. The shift amount is b[4:0]. With set-cc, the flags follow the R4 rule.
- R6: Opcode 13 (multiply step) saves a[0], forms {N^V, a[31:1]}, adds b to it when Y[0]=1 and adds zero otherwise, and sets the flags by the R1 rule whatever the set-cc strobe is. Y then becomes {saved a[0], Y[31:1]}.
- R7: Opcode 14 (write Y) loads a into Y on the next edge and returns a on res_o. Opcode 15 (read Y) returns the current Y on res_o. With set-cc, both set the flags by the R4 rule.
- R8: flags_o loads flags_nxt_o on the clock edge only when set-cc is high or the opcode is 13. Otherwise it keeps its value.
- R9: y_o changes only after opcode 13 or opcode 14.
- R10: While rst_ni is low, flags_o and y_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| setcc_i | input | 1 | Update the condition codes with this operation |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand / shift amount |
| res_o | output | 32 | Combinational result |
| flags_nxt_o | output | 4 | Next condition codes {N,Z,V,C} |
| y_nxt_o | output | 32 | Next Y value |
| flags_o | output | 4 | Registered condition codes |
| y_o | output | 32 | Registered Y |

## Verification
The bench builds the unit with its default 32-bit width. This is the width at which the bit-31 overflow rules, the 5-bit shift field and the 32 possible shift amounts are all defined. At this width, directed vectors can hit the signed and unsigned overflow boundaries at 0x7fffffff and 0xffffffff, shifts whose amount field wraps (33 acts as 1), and multiply-step chains that feed each result back as the next partial product. A reference model written from the requirements predicts every combinational and registered output for directed and random operations.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUBC  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_ORN   = 4'd8,
    OP_XNOR  = 4'd9,
    OP_SLL   = 4'd10,
    OP_SRL   = 4'd11,
    OP_SRA   = 4'd12,
    OP_MSTEP = 4'd13,
    OP_WRY   = 4'd14,
    OP_RDY   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} sh_mode_e;
endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,   // extra +1 (add) or extra -1 (sub)
  output logic [W-1:0] sum_o,
  output logic         c_o,     // carry (add) or borrow (sub)
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic         ci_eff;
  logic         co;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign ci_eff = sub_i ? ~cin_i : cin_i;
  assign {co, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};
  assign c_o = sub_i ? ~co : co;
  assign v_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic
  import cc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] b_sel;

  // and-not, or-not, xnor use complemented b
  assign b_sel = (op_i inside {OP_ANDN, OP_ORN, OP_XNOR}) ? ~b_i : b_i;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_ANDN: res_o = a_i & b_sel;
      OP_OR,  OP_ORN:  res_o = a_i | b_sel;
      OP_XOR, OP_XNOR: res_o = a_i ^ b_sel;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/cc_alu_shift.sv
module cc_alu_shift
  import cc_alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  sh_mode_e      mode_i,
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] a_rev, out_rev;
  logic [W-1:0] stage [SW+1];
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]   = a_i[W-1-i];
    assign out_rev[i] = stage[SW][W-1-i];
  end

  // left shift = right shift of the bit-reversed word
  assign stage[0] = (mode_i == SH_LEFT) ? a_rev : a_i;
  assign fill     = (mode_i == SH_RARI) & a_i[W-1];

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  assign res_o = (mode_i == SH_LEFT) ? out_rev : stage[SW];
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   op_i,
  input  logic         setcc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_nxt_o,
  output logic [W-1:0] y_nxt_o,
  output logic [3:0]   flags_o,
  output logic [W-1:0] y_o
);
  localparam int unsigned SW = $clog2(W);

  alu_op_e      op;
  cc_t          cc_q, cc_calc, cc_d;
  logic [W-1:0] y_q, y_d;
  logic [W-1:0] add_a, add_b, add_sum, log_res, sh_res;
  logic         add_sub, add_cin, add_c, add_v;
  logic         is_arith, cc_we;
  sh_mode_e     sh_mode;

  assign op = alu_op_e'(op_i);

  // multiply step reuses the adder with a shifted partial product
  always_comb begin
    add_a = a_i;
    add_b = b_i;
    if (op == OP_MSTEP) begin
      add_a = {cc_q.n ^ cc_q.v, a_i[W-1:1]};
      add_b = y_q[0] ? b_i : '0;
    end
  end

  assign add_sub  = op inside {OP_SUB, OP_SUBC};
  assign add_cin  = (op inside {OP_ADDC, OP_SUBC}) & cc_q.c;
  assign is_arith = op inside {OP_ADD, OP_SUB, OP_ADDC, OP_SUBC, OP_MSTEP};

  cc_alu_addsub #(.W(W)) u_addsub (
    .a_i   (add_a),
    .b_i   (add_b),
    .sub_i (add_sub),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .c_o   (add_c),
    .v_o   (add_v)
  );

  cc_alu_logic #(.W(W)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (log_res)
  );

  always_comb begin
    unique case (op)
      OP_SRL:  sh_mode = SH_RLOG;
      OP_SRA:  sh_mode = SH_RARI;
      default: sh_mode = SH_LEFT;
    endcase
  end

  cc_alu_shift #(.W(W), .SW(SW)) u_shift (
    .mode_i (sh_mode),
    .a_i    (a_i),
    .amt_i  (b_i[SW-1:0]),
    .res_o  (sh_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBC, OP_MSTEP: res_o = add_sum;
      OP_AND, OP_OR, OP_XOR,
      OP_ANDN, OP_ORN, OP_XNOR:                   res_o = log_res;
      OP_SLL, OP_SRL, OP_SRA:                     res_o = sh_res;
      OP_WRY:                                     res_o = a_i;
      OP_RDY:                                     res_o = y_q;
      default:                                    res_o = '0;
    endcase
  end

  assign cc_calc.n = res_o[W-1];
  assign cc_calc.z = (res_o == '0);
  assign cc_calc.v = is_arith & add_v;
  assign cc_calc.c = is_arith & add_c;

  assign cc_we = setcc_i | (op == OP_MSTEP);
  assign cc_d  = cc_we ? cc_calc : cc_q;

  always_comb begin
    unique case (op)
      OP_MSTEP: y_d = {a_i[0], y_q[W-1:1]};
      OP_WRY:   y_d = a_i;
      default:  y_d = y_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q <= '0;
      y_q  <= '0;
    end else begin
      cc_q <= cc_d;
      y_q  <= y_d;
    end
  end

  assign flags_nxt_o = cc_d;
  assign y_nxt_o     = y_d;
  assign flags_o     = cc_q;
  assign y_o         = y_q;
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk
  import cc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   op_i,
  input logic         setcc_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic [3:0]   flags_nxt_o,
  input logic [W-1:0] y_nxt_o,
  input logic [3:0]   flags_o,
  input logic [W-1:0] y_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (flags_o == 4'h0 && y_o == '0); // R10
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !setcc_i && op_i != OP_MSTEP |=> flags_o == $past(flags_o)); // R8

  AST_FLAGS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (setcc_i || op_i == OP_MSTEP) |=> flags_o == $past(flags_nxt_o)); // R8

  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && op_i != OP_MSTEP && op_i != OP_WRY |=> $stable(y_o)); // R9

  AST_Y_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && op_i == OP_WRY |=> y_o == $past(a_i)); // R7

  AST_MSTEP_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && op_i == OP_MSTEP |=> y_o == {$past(a_i[0]), $past(y_o[W-1:1])}); // R6

  AST_LOGIC_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setcc_i && op_i inside {OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_XNOR,
                            OP_SLL, OP_SRL, OP_SRA} |-> flags_nxt_o[1:0] == 2'b00); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setcc_i |-> flags_nxt_o[2] == (res_o == '0)); // R1
endmodule

bind cc_alu cc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/cc_alu_tb.sv
module cc_alu_tb;
  localparam int W = 32;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic [3:0]  nf;
    logic [31:0] ny;
    logic [3:0]  cf;
    logic [31:0] cy;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [3:0]  op = '0;
  logic        setcc = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res, ny, y;
  logic [3:0]  nf, f;

  int n_chk = 0, n_fail = 0;
  item_t q[$];
  logic [3:0]  m_f = '0;
  logic [31:0] m_y = '0, last_res = '0;
  bit          done = 0;

  always #2 clk = ~clk;  // 250 MHz

  cc_alu #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .setcc_i(setcc),
    .a_i(a), .b_i(b), .res_o(res), .flags_nxt_o(nf), .y_nxt_o(ny),
    .flags_o(f), .y_o(y)
  );

  // reference model; flags {N,Z,V,C}
  function automatic void model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] z,
                                input logic sc, input logic [3:0] cf, input logic [31:0] cy,
                                output logic [31:0] r, output logic [3:0] nfl, output logic [31:0] nyv);
    logic [32:0] wide;
    logic [31:0] s, bb;
    logic vv, cc, ar;
    ar = 1'b1; vv = 1'b0; cc = 1'b0; nyv = cy;
    case (o)
      4'd0: begin r = x + z; cc = r < x; vv = ((~(x ^ z)) & (x ^ r)) >> 31; end
      4'd1: begin r = x - z; cc = x < z; vv = ((x ^ z) & (x ^ r)) >> 31; end
      4'd2: begin wide = {1'b0, x} + {1'b0, z} + {32'd0, cf[0]}; r = wide[31:0]; cc = wide[32];
                  vv = ((~(x ^ z)) & (x ^ r)) >> 31; end
      4'd3: begin r = x - z - {31'd0, cf[0]}; cc = ({1'b0, x} < ({1'b0, z} + {32'd0, cf[0]}));
                  vv = ((x ^ z) & (x ^ r)) >> 31; end
      4'd4: begin r = x & z; ar = 0; end
      4'd5: begin r = x | z; ar = 0; end
      4'd6: begin r = x ^ z; ar = 0; end
      4'd7: begin r = x & ~z; ar = 0; end
      4'd8: begin r = x | ~z; ar = 0; end
      4'd9: begin r = ~(x ^ z); ar = 0; end
      4'd10: begin r = x << z[4:0]; ar = 0; end
      4'd11: begin r = x >> z[4:0]; ar = 0; end
      4'd12: begin r = $unsigned($signed(x) >>> z[4:0]); ar = 0; end
      4'd13: begin
        s  = {cf[3] ^ cf[1], x[31:1]};
        bb = cy[0] ? z : 32'd0;
        r  = s + bb; cc = r < s; vv = ((~(s ^ bb)) & (s ^ r)) >> 31;
        nyv = {x[0], cy[31:1]};
      end
      4'd14: begin r = x; ar = 0; nyv = x; end
      default: begin r = cy; ar = 0; end
    endcase
    if (!ar) begin vv = 0; cc = 0; end
    if (sc || o == 4'd13) nfl = {r[31], r == 32'd0, vv, cc};
    else nfl = cf;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] z,
                       input logic sc, input string tag);
    item_t it;
    @(negedge clk);
    op = o; a = x; b = z; setcc = sc;
    it.tag = tag; it.cf = m_f; it.cy = m_y;
    model(o, x, z, sc, m_f, m_y, it.res, it.nf, it.ny);
    q.push_back(it);
    m_f = it.nf; m_y = it.ny; last_res = it.res;
  endtask

  // monitor: sample mid-cycle, after the driver has settled
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        n_chk++;
        if (res !== e.res || nf !== e.nf || ny !== e.ny || f !== e.cf || y !== e.cy) begin
          n_fail++;
          $display("FAIL %s: res=%h nf=%h ny=%h f=%h y=%h expected res=%h nf=%h ny=%h f=%h y=%h",
                   e.tag, res, nf, ny, f, y, e.res, e.nf, e.ny, e.cf, e.cy);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (f !== 4'h0 || y !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 reset: f=%h y=%h expected f=0 y=0", f, y);
    end
    @(negedge clk); rst_ni = 1'b1;
    #1;
    n_chk++;
    if (f !== 4'h0 || y !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 after release: f=%h y=%h expected f=0 y=0", f, y);
    end

    // R1 add
    drive(4'd0, 32'd5, 32'd7, 1, "R1 add small");
    drive(4'd0, 32'h7fffffff, 32'd1, 1, "R1 add signed overflow");
    drive(4'd0, 32'hffffffff, 32'd1, 1, "R1 add carry zero");
    drive(4'd0, 32'h80000000, 32'h80000000, 1, "R1 add both neg");
    drive(4'd0, 32'd1, 32'd2, 0, "R8 add no setcc keeps flags");
    // R2 sub
    drive(4'd1, 32'd5, 32'd5, 1, "R2 sub zero");
    drive(4'd1, 32'd0, 32'd1, 1, "R2 sub borrow");
    drive(4'd1, 32'h80000000, 32'd1, 1, "R2 sub overflow");
    drive(4'd1, 32'h7fffffff, 32'hffffffff, 1, "R2 sub pos-neg overflow");
    // R3 carry ops
    drive(4'd0, 32'hffffffff, 32'd1, 1, "R3 set carry");
    drive(4'd2, 32'd1, 32'd2, 0, "R3 addc with C=1");
    drive(4'd2, 32'hffffffff, 32'hffffffff, 1, "R3 addc carry out");
    drive(4'd3, 32'd10, 32'd3, 1, "R3 subc with C=1");
    drive(4'd3, 32'd3, 32'd3, 1, "R3 subc C=0");
    drive(4'd0, 32'hffffffff, 32'd1, 1, "R3 set carry again");
    drive(4'd3, 32'd3, 32'd3, 1, "R3 subc borrow with C=1");
    // R4 logic
    drive(4'd4, 32'hf0f0_ff00, 32'h0ff0_0f0f, 1, "R4 and");
    drive(4'd5, 32'h0, 32'h0, 1, "R4 or zero");
    drive(4'd6, 32'haaaa5555, 32'h5555aaaa, 1, "R4 xor");
    drive(4'd7, 32'hffffffff, 32'h0000ffff, 1, "R4 andn");
    drive(4'd8, 32'h00000001, 32'hffffffff, 1, "R4 orn");
    drive(4'd9, 32'h12345678, 32'h12345678, 1, "R4 xnor");
    drive(4'd0, 32'h7fffffff, 32'h1, 1, "R4 set V before logic");
    drive(4'd5, 32'h00000003, 32'h4, 1, "R4 logic clears V C");
    // R5 shifts
    drive(4'd10, 32'd1, 32'd31, 1, "R5 sll 31");
    drive(4'd11, 32'h80000000, 32'd4, 1, "R5 srl 4");
    drive(4'd12, 32'h80000000, 32'd4, 1, "R5 sra 4");
    drive(4'd12, 32'h80000010, 32'd33, 0, "R5 sra amount wraps");
    drive(4'd10, 32'hdeadbeef, 32'd32, 1, "R5 sll amount 32 acts as 0");
    drive(4'd12, 32'h40000000, 32'd30, 0, "R5 sra positive");
    // R7 Y access
    drive(4'd14, 32'h12345678, 32'd0, 0, "R7 write Y");
    drive(4'd15, 32'd0, 32'd0, 0, "R7 read Y");
    drive(4'd15, 32'd0, 32'd0, 1, "R7 read Y setcc");
    // R6 multiply step: 13 x 11 via step chain
    drive(4'd14, 32'd11, 32'd0, 0, "R6 load multiplier");
    drive(4'd5, 32'd0, 32'd0, 1, "R6 clear flags");
    drive(4'd13, 32'd0, 32'd13, 0, "R6 step 1");
    for (int i = 0; i < 8; i++) drive(4'd13, last_res, 32'd13, 0, "R6 step chain");
    drive(4'd14, 32'h0, 32'd0, 0, "R6 Y zero");
    drive(4'd13, 32'h00000003, 32'hffffffff, 0, "R6 step skip add");
    drive(4'd14, 32'h1, 32'd0, 0, "R6 Y one");
    drive(4'd0, 32'h7fffffff, 32'h1, 1, "R6 set N and V");
    drive(4'd13, 32'h7fffffff, 32'h1, 0, "R6 step N^V shifted in");
    drive(4'd13, 32'h80000001, 32'h7fffffff, 0, "R6 step overflow");
    // R9 Y hold on other ops
    drive(4'd0, 32'd1, 32'd1, 1, "R9 Y held on add");
    drive(4'd15, 32'd0, 32'd0, 0, "R9 Y read back");
    // mixed random
    for (int i = 0; i < 300; i++)
      drive(4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom_range(0, 1)), "R8 R9 random mix");

    repeat (3) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard drain: actual %0d left expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule